// File: doc/BRIEF.md
# Signed/Unsigned Word Width Converter with Loss Flag

This block resizes a 16-bit data word. A direction input selects one of two results. Widening produces a 32-bit word. Narrowing produces an 8-bit word, which sits in the low bits of the 32-bit output port with zeros above it.

A second input chooses how the word is read: as an unsigned value or as a two's-complement signed value. On widening, an unsigned word gets zeros in its new upper bits. A signed word gets copies of its top bit instead.

On narrowing, the upper bits are dropped and the block raises a loss flag whenever the narrow result no longer stands for the same number. It never saturates or clamps. Results are registered when the input qualifier is high, and an output strobe marks the cycle in which they appear.

The three widths are parameters. If the narrow width equals the input width, the narrowing path passes the word through and never reports loss.

Top module: `wcv_top`

## Requirements
- R1: While `rst` is high at a rising edge, `out_data`, `lossy` and `out_valid` are all 0 after that edge.
- R2: `out_valid` is 1 in the cycle after a rising edge that sampled `in_valid`=1, and 0 after an edge that sampled `in_valid`=0.
- R3: An edge that samples `in_valid`=0 leaves `out_data` and `lossy` unchanged.
- R4: With `narrow`=0 (widen) and `is_signed`=0, `out_data` is the input with bits 31..16 set to 0, and `lossy` is 0 (0x00F3 gives 0x000000F3).
- R5: With `narrow`=0 and `is_signed`=1, bits 31..16 of `out_data` copy input bit 15, bits 15..0 equal the input, and `lossy` is 0 (0xFFEB, which is -21, gives 0xFFFFFFEB).
- R6: With `narrow`=1, `out_data` bits 7..0 equal input bits 7..0 and bits 31..8 are 0.
- R7: With `narrow`=1 and `is_signed`=0, `lossy` is 1 exactly when any of input bits 15..8 is 1 (0x003F is kept, 0x103F is lossy).
- R8: With `narrow`=1 and `is_signed`=1, `lossy` is 0 exactly when input bits 15..7 are all 0 or all 1 (0xFF80 is kept, 0xFF3F and 0x0080 are lossy).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_data`, `is_signed` and `narrow` |
| in_data | input | 16 | Word to resize |
| is_signed | input | 1 | 1: two's-complement signed, 0: unsigned |
| narrow | input | 1 | 1: narrow to 8 bits, 0: widen to 32 bits |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 32 | Resized word, narrow result zero-padded |
| lossy | output | 1 | Narrow result does not equal the input value |

## Verification
Several properties are checked on every cycle:
- the strobe timing;
- that idle cycles hold the registers;
- that widening never flags loss;
- that the upper bits of a signed widening copy the sign;
- that a narrow result has zeros above bit 7;
- that the unsigned loss rule holds.

The signed narrowing rule is shown only by the bench scenarios. These place values just inside and just outside the signed 8-bit range (0x007F, 0x0080, 0xFF80, 0xFF7F) and the mixed case 0xFF3F. The bench scenarios also show reset arriving in the middle of traffic and back-to-back words that switch mode on every cycle.

// File: rtl/wcv_pkg.sv
package wcv_pkg;
    typedef enum logic {
        DIR_WIDEN  = 1'b0,
        DIR_NARROW = 1'b1
    } dir_e;

    typedef enum logic {
        NUM_UNSIGNED = 1'b0,
        NUM_SIGNED   = 1'b1
    } num_e;
endpackage

// File: rtl/wcv_widen.sv
module wcv_widen #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  din,
    input  logic             sgn,
    output logic [OUT_W-1:0] dout
);
    generate
        if (OUT_W > IN_W) begin : g_ext
            localparam int FILL_W = OUT_W - IN_W;
            logic fill_bit;
            always_comb begin
                fill_bit = sgn & din[IN_W-1];
                dout     = {{FILL_W{fill_bit}}, din};
            end
        end else begin : g_pass
            logic unused_sgn;
            always_comb begin
                unused_sgn = sgn;
                dout       = din[OUT_W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/wcv_narrow.sv
module wcv_narrow #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  din,
    input  logic             sgn,
    output logic [OUT_W-1:0] dout,
    output logic             loss
);
    generate
        if (OUT_W < IN_W) begin : g_cut
            localparam int DROP_W = IN_W - OUT_W;
            logic [DROP_W:0] span;
            logic            span_ones;
            logic            span_zeros;
            logic            drop_any;
            always_comb begin
                dout       = din[OUT_W-1:0];
                span       = din[IN_W-1:OUT_W-1];
                span_ones  = &span;
                span_zeros = ~|span;
                drop_any   = |din[IN_W-1:OUT_W];
                if (sgn) begin
                    loss = ~(span_ones | span_zeros);
                end else begin
                    loss = drop_any;
                end
            end
        end else begin : g_pass
            logic unused_sgn;
            always_comb begin
                unused_sgn = sgn;
                dout       = OUT_W'(din);
                loss       = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/wcv_top.sv
module wcv_top #(
    parameter int IN_W     = 16,
    parameter int WIDE_W   = 32,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_data,
    input  logic              is_signed,
    input  logic              narrow,
    output logic              out_valid,
    output logic [WIDE_W-1:0] out_data,
    output logic              lossy
);
    import wcv_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [WIDE_W-1:0] data;
        logic              lossy;
    } state_t;

    state_t state_d, state_q;

    logic [WIDE_W-1:0]   wide_res;
    logic [NARROW_W-1:0] nar_res;
    logic                nar_loss;
    dir_e                dir;
    num_e                num;

    assign dir = dir_e'(narrow);
    assign num = num_e'(is_signed);

    wcv_widen #(.IN_W(IN_W), .OUT_W(WIDE_W)) u_widen (
        .din  (in_data),
        .sgn  (num == NUM_SIGNED),
        .dout (wide_res)
    );

    wcv_narrow #(.IN_W(IN_W), .OUT_W(NARROW_W)) u_narrow (
        .din  (in_data),
        .sgn  (num == NUM_SIGNED),
        .dout (nar_res),
        .loss (nar_loss)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            if (dir == DIR_NARROW) begin
                state_d.data  = WIDE_W'(nar_res);
                state_d.lossy = nar_loss;
            end else begin
                state_d.data  = wide_res;
                state_d.lossy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign out_data  = state_q.data;
    assign lossy     = state_q.lossy;
endmodule

// File: rtl/wcv_top_chk.sv
module wcv_top_chk #(
    parameter int IN_W     = 16,
    parameter int WIDE_W   = 32,
    parameter int NARROW_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [IN_W-1:0]   in_data,
    input logic              is_signed,
    input logic              narrow,
    input logic              out_valid,
    input logic [WIDE_W-1:0] out_data,
    input logic              lossy
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!out_valid && !lossy && out_data == '0)); // R1
    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R2
    AST_STROBE_DROPS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(out_data) && $stable(lossy))); // R3
    AST_WIDEN_NO_LOSS: assert property (@(posedge clk) disable iff (rst) (in_valid && !narrow) |=> !lossy); // R4
    AST_WIDEN_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !narrow && is_signed) |=> out_data[WIDE_W-1:IN_W] == {(WIDE_W-IN_W){$past(in_data[IN_W-1])}}); // R5
    AST_NARROW_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && narrow) |=> out_data[WIDE_W-1:NARROW_W] == '0); // R6

    generate
        if (NARROW_W < IN_W) begin : g_uns
            AST_UNS_LOSS_RULE: assert property (@(posedge clk) disable iff (rst)
                (in_valid && narrow && !is_signed) |=> lossy == ($past(in_data[IN_W-1:NARROW_W]) != '0)); // R7
        end
    endgenerate
endmodule

bind wcv_top wcv_top_chk #(.IN_W(IN_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/wcv_top_test.sv
module wcv_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        is_signed = 1'b0;
    logic        narrow = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        lossy;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] data;
        logic        loss;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    wcv_top uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .is_signed(is_signed), .narrow(narrow),
        .out_valid(out_valid), .out_data(out_data), .lossy(lossy)
    );

    function automatic exp_t model(logic [15:0] x, bit sg, bit nr);
        exp_t e;
        int v;
        v = sg ? int'($signed(x)) : int'(x);
        if (!nr) begin
            e.data = v;
            e.loss = 1'b0;
            e.req  = sg ? "R5" : "R4";
        end else begin
            e.data = {24'd0, x[7:0]};
            e.loss = sg ? (v < -128 || v > 127) : (v > 255);
            e.req  = sg ? "R8/R6" : "R7/R6";
        end
        return e;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic [15:0] x, bit sg, bit nr);
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = x;
        is_signed = sg;
        narrow    = nr;
        sb.push_back(model(x, sg, nr));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 16'hA5A5;
        end
    endtask

    // monitor: compare each strobed result against the scoreboard head
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check("R2 unexpected strobe", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, out_data, e.data);
                check({e.req, " lossy"}, {31'd0, lossy}, {31'd0, e.loss});
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check("R1 out_data", out_data, 32'd0);
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 lossy", {31'd0, lossy}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        drive(16'h00F3, 0, 0);   // R4
        drive(16'h00F3, 1, 0);   // R5 positive
        drive(16'hFFF3, 1, 0);   // R5
        drive(16'hFFEB, 1, 0);   // R5 (-21)
        drive(16'hFFEB, 0, 0);   // R4
        drive(16'h003F, 0, 1);   // R7 kept
        drive(16'h103F, 0, 1);   // R7 lossy
        drive(16'hFF3F, 1, 1);   // R8 lossy
        drive(16'h003F, 1, 1);   // R8 kept
        drive(16'h007F, 1, 1);   // R8 kept
        drive(16'h0080, 1, 1);   // R8 lossy
        drive(16'h0080, 0, 1);   // R7 kept
        drive(16'hFF80, 1, 1);   // R8 kept
        drive(16'hFF7F, 1, 1);   // R8 lossy
        drive(16'hFFFF, 1, 1);   // R8 kept
        drive(16'h8000, 0, 1);   // R7 lossy
        idle(1);
        @(negedge clk);
        check("R2 strobe low after idle", {31'd0, out_valid}, 32'd0);

        drive(16'h103F, 0, 1);   // leaves lossy=1
        idle(1);
        held = out_data;
        idle(3);
        check("R3 data held", out_data, held);
        check("R3 lossy held", {31'd0, lossy}, 32'd1);
        check("R2 no strobe while idle", {31'd0, out_valid}, 32'd0);

        lf = 16'hACE1;
        for (int i = 0; i < 200; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            drive(lf, lf[3], lf[6]);
        end
        idle(2);

        drive(16'hFF3F, 1, 1);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        sb.delete();
        @(negedge clk);
        check("R1 mid-run data", out_data, 32'd0);
        check("R1 mid-run valid", {31'd0, out_valid}, 32'd0);
        check("R1 mid-run lossy", {31'd0, lossy}, 32'd0);
        rst = 1'b0;
        drive(16'h8001, 1, 0);   // R5
        idle(2);
        check("R2 scoreboard drained", sb.size(), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule